// File: doc/BRIEF.md
# Receive Signal and Clock Loss Monitor

This block watches the receive side of a 2.048 Mbit/s line interface. It lives in the domain of a free-running reference clock. The recovered receive clock and the two recovered data rails enter through a synchroniser chain. Two things are tracked from there: how long the recovered data has carried no mark, and how long the recovered clock has gone without a transition.

The loss-of-signal alarm is raised in two ways. One is a digital run-of-zeros detector. The other is an external analog detect input, and that input is ignored while the interface is in local loopback. The loss-of-clock alarm is raised in two cases: when the recovered clock stops, or when shutdown is enabled while loss of signal is active. Both alarms are active-low.

When shutdown is enabled and loss of signal is active, the receive clock and data outputs are held at fixed levels. Those levels depend on the rail format. An active-low alarm-test input drives both alarms to their alarm state and leaves the data path alone.

Top module: `los_loc_monitor`

## Requirements
- R1: Counting on rising edges of the synchronised receive clock, a sample is a mark when either rail is 1. A run of up to ZERO_LIMIT (32) consecutive zero samples leaves los_n high. The (ZERO_LIMIT+1)th consecutive zero drives los_n low.
- R2: The first mark sample after a long zero run clears the digital detector, and los_n returns high when no other loss source is active. The run counter saturates and does not wrap.
- R3: With loop_local = 0, ana_los = 1 drives los_n low even when marks are arriving.
- R4: With loop_local = 1, ana_los has no effect, and los_n follows the digital detector only.
- R5: sd_en = 1 while loss of signal is active drives loc_n low.
- R6: When the synchronised receive clock has no transition for ABSENT_CYC (13) reference cycles, loc_n goes low. A gap of 6 reference cycles does not lower it.
- R7: Once the clock returns, loc_n goes high again no later than 8 reference cycles after the first returning edge.
- R8: Forced state in single-rail format (dual_rail = 0), under shutdown with loss of signal: rx_clk_out = 1, rx_pos_out = 0, rx_neg_out = 0.
- R9: Forced state in dual-rail, true polarity (dual_rail = 1, inv_mode = 0): rx_clk_out = 1, both rails 0.
- R10: Forced state in dual-rail, inverted polarity (dual_rail = 1, inv_mode = 1): rx_clk_out = 0, both rails 1.
- R11: When outputs are not forced, they follow the synchronised inputs after 3 reference cycles, by format:
  - single-rail: rx_pos_out = pos OR neg, rx_neg_out = 0, clock passes through;
  - dual true: rails and clock pass through unchanged;
  - dual inverted: clock and both rails are inverted.
- R12: alm_test_n = 0 drives los_n and loc_n low and does not change the receive outputs.
- R13: While rst is high, los_n and loc_n are 1 and all three receive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_in | input | 1 | Recovered receive clock (asynchronous) |
| rx_pos_in | input | 1 | Recovered positive rail / single-rail data |
| rx_neg_in | input | 1 | Recovered negative rail |
| ana_los | input | 1 | Analog detector reports no signal (active high) |
| loop_local | input | 1 | Local loopback active; analog detector ignored |
| sd_en | input | 1 | Shutdown enable |
| alm_test_n | input | 1 | Alarm test, active low |
| dual_rail | input | 1 | 0 single-rail, 1 dual-rail output format |
| inv_mode | input | 1 | Inverted polarity in dual-rail format |
| los_n | output | 1 | Loss of signal, active low |
| loc_n | output | 1 | Loss of clock, active low |
| rx_clk_out | output | 1 | Receive clock toward terminal equipment |
| rx_pos_out | output | 1 | Receive data / positive rail |
| rx_neg_out | output | 1 | Receive negative rail |

## Verification
The bench keeps the default parameters: two synchroniser stages, ZERO_LIMIT of 32 and ABSENT_CYC of 13. It runs the recovered clock at eight reference cycles per bit. At that rate a 33-zero run takes only a few hundred cycles, so both sides of the 32/33 boundary can be exercised directly. One clock period is also well inside the 13-cycle gap window. Stopping the clock for 6 cycles and then for 26 cycles checks that no absence is flagged early and that the flag does appear. The returning edge is then checked against the 8-cycle restore window.

// File: rtl/los_mon_pkg.sv
package los_mon_pkg;

  typedef enum logic [1:0] {
    FMT_SINGLE    = 2'd0,
    FMT_DUAL_TRUE = 2'd1,
    FMT_DUAL_INV  = 2'd2
  } rx_fmt_e;

  typedef struct packed {
    logic clk;
    logic pos;
    logic neg;
  } rx_bus_t;

  // The single-rail / inverted combination is not legal; it falls back to single-rail.
  function automatic rx_fmt_e pick_fmt(input logic dual, input logic inv);
    if (!dual)     return FMT_SINGLE;
    else if (inv)  return FMT_DUAL_INV;
    else           return FMT_DUAL_TRUE;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/clk_gap_mon.sv
module clk_gap_mon #(
  parameter int ABSENT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic rclk_s,
  output logic rise,
  output logic absent
);
  localparam int CW = $clog2(ABSENT_CYC + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(ABSENT_CYC);

  logic          prev_q;
  logic [CW-1:0] gap_q, gap_nxt;
  logic          tgl;

  assign tgl  = rclk_s ^ prev_q;
  assign rise = rclk_s & ~prev_q;

  always_comb begin
    if (tgl)                 gap_nxt = '0;
    else if (gap_q == GAP_MAX) gap_nxt = gap_q;
    else                     gap_nxt = gap_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
      absent <= 1'b0;
    end else begin
      prev_q <= rclk_s;
      gap_q  <= gap_nxt;
      absent <= !tgl && (gap_nxt == GAP_MAX);
    end
  end

  // R7
  edge_clears_absent_chk: assert property (@(posedge clk) disable iff (rst)
    tgl |=> !absent);
  // R6
  absent_needs_full_gap_chk: assert property (@(posedge clk) disable iff (rst)
    absent |-> (gap_q == GAP_MAX));
endmodule

// File: rtl/zero_run_det.sv
module zero_run_det #(
  parameter int ZERO_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic mark,
  output logic dig_los
);
  localparam int ZW = $clog2(ZERO_LIMIT + 2);
  localparam logic [ZW-1:0] RUN_SAT = ZW'(ZERO_LIMIT + 1);

  logic [ZW-1:0] run_q, run_nxt;

  always_comb begin
    if (mark)                run_nxt = '0;
    else if (run_q == RUN_SAT) run_nxt = run_q;
    else                     run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      dig_los <= 1'b0;
    end else if (sample) begin
      run_q   <= run_nxt;
      dig_los <= (run_nxt == RUN_SAT);
    end
  end

  // R2
  mark_clears_los_chk: assert property (@(posedge clk) disable iff (rst)
    (sample && mark) |=> !dig_los);
  // R2
  run_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_SAT);
  // R1
  los_only_at_sat_chk: assert property (@(posedge clk) disable iff (rst)
    dig_los |-> (run_q == RUN_SAT));
endmodule

// File: rtl/rx_out_fmt.sv
import los_mon_pkg::*;

module rx_out_fmt (
  input  logic    clk,
  input  logic    rst,
  input  rx_fmt_e fmt,
  input  logic    force_off,
  input  logic    rclk_s,
  input  logic    pos_s,
  input  logic    neg_s,
  output logic    oclk,
  output logic    opos,
  output logic    oneg
);
  logic c_d, p_d, n_d;

  always_comb begin
    case (fmt)
      FMT_DUAL_TRUE: begin
        c_d = force_off ? 1'b1 : rclk_s;
        p_d = force_off ? 1'b0 : pos_s;
        n_d = force_off ? 1'b0 : neg_s;
      end
      FMT_DUAL_INV: begin
        c_d = force_off ? 1'b0 : ~rclk_s;
        p_d = force_off ? 1'b1 : ~pos_s;
        n_d = force_off ? 1'b1 : ~neg_s;
      end
      default: begin
        c_d = force_off ? 1'b1 : rclk_s;
        p_d = force_off ? 1'b0 : (pos_s | neg_s);
        n_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oclk <= 1'b0;
      opos <= 1'b0;
      oneg <= 1'b0;
    end else begin
      oclk <= c_d;
      opos <= p_d;
      oneg <= n_d;
    end
  end

  // R8
  force_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_off && fmt == FMT_SINGLE)) |-> (oclk && !opos && !oneg));
  // R9
  force_dual_true_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_off && fmt == FMT_DUAL_TRUE)) |-> (oclk && !opos && !oneg));
  // R10
  force_dual_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_off && fmt == FMT_DUAL_INV)) |-> (!oclk && opos && oneg));
endmodule

// File: rtl/los_loc_monitor.sv
import los_mon_pkg::*;

module los_loc_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int ZERO_LIMIT  = 32,
  parameter int ABSENT_CYC  = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_clk_in,
  input  logic rx_pos_in,
  input  logic rx_neg_in,
  input  logic ana_los,
  input  logic loop_local,
  input  logic sd_en,
  input  logic alm_test_n,
  input  logic dual_rail,
  input  logic inv_mode,
  output logic los_n,
  output logic loc_n,
  output logic rx_clk_out,
  output logic rx_pos_out,
  output logic rx_neg_out
);
  localparam int BUS_W = $bits(rx_bus_t);

  rx_bus_t          raw_bus, syn_bus;
  logic [BUS_W-1:0] syn_vec;
  logic             rise, absent, dig_los, los_act, force_off;
  rx_fmt_e          fmt;

  assign raw_bus = '{clk: rx_clk_in, pos: rx_pos_in, neg: rx_neg_in};
  assign syn_bus = rx_bus_t'(syn_vec);

  rx_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_bus), .sync_out(syn_vec));

  clk_gap_mon #(.ABSENT_CYC(ABSENT_CYC)) u_gap (
    .clk(clk), .rst(rst), .rclk_s(syn_bus.clk), .rise(rise), .absent(absent));

  zero_run_det #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk(clk), .rst(rst), .sample(rise), .mark(syn_bus.pos | syn_bus.neg),
    .dig_los(dig_los));

  assign fmt       = pick_fmt(dual_rail, inv_mode);
  assign los_act   = dig_los | (ana_los & ~loop_local);
  assign force_off = sd_en & los_act;

  rx_out_fmt u_fmt (
    .clk(clk), .rst(rst), .fmt(fmt), .force_off(force_off),
    .rclk_s(syn_bus.clk), .pos_s(syn_bus.pos), .neg_s(syn_bus.neg),
    .oclk(rx_clk_out), .opos(rx_pos_out), .oneg(rx_neg_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      los_n <= 1'b1;
      loc_n <= 1'b1;
    end else begin
      los_n <= !(los_act || !alm_test_n);
      loc_n <= !(absent || force_off || !alm_test_n);
    end
  end

  // R12
  alarm_test_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alm_test_n)) |-> (!los_n && !loc_n));
  // R3
  analog_los_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ana_los && !loop_local)) |-> !los_n);
  // R4
  loop_ignores_analog_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loop_local && !dig_los && alm_test_n)) |-> los_n);
  // R5
  shutdown_loc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sd_en && (dig_los || (ana_los && !loop_local)))) |-> !loc_n);
endmodule

// File: tb/tb_los_loc_monitor.sv
module tb_los_loc_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_clk_in = 1'b0, rx_pos_in = 1'b0, rx_neg_in = 1'b0;
  logic ana_los = 1'b0, loop_local = 1'b0, sd_en = 1'b0, alm_test_n = 1'b1;
  logic dual_rail = 1'b0, inv_mode = 1'b0;
  logic los_n, loc_n, rx_clk_out, rx_pos_out, rx_neg_out;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  los_loc_monitor dut (
    .clk(clk), .rst(rst), .rx_clk_in(rx_clk_in), .rx_pos_in(rx_pos_in),
    .rx_neg_in(rx_neg_in), .ana_los(ana_los), .loop_local(loop_local),
    .sd_en(sd_en), .alm_test_n(alm_test_n), .dual_rail(dual_rail),
    .inv_mode(inv_mode), .los_n(los_n), .loc_n(loc_n),
    .rx_clk_out(rx_clk_out), .rx_pos_out(rx_pos_out), .rx_neg_out(rx_neg_out));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: falling edge with new data, 4 cycles low, rising edge, 4 cycles high
  task automatic send_bit(input logic b);
    rx_clk_in = 1'b0; rx_pos_in = b; rx_neg_in = 1'b0;
    wait_n(4);
    rx_clk_in = 1'b1;
    wait_n(4);
  endtask

  task automatic idle_low(input int n);
    rx_clk_in = 1'b0;
    wait_n(n);
  endtask

  task automatic t_reset;
    wait_n(5);
    chk("R13 los_n", los_n, 1'b1);
    chk("R13 loc_n", loc_n, 1'b1);
    chk("R13 clk_out", rx_clk_out, 1'b0);
    chk("R13 pos_out", rx_pos_out, 1'b0);
    chk("R13 neg_out", rx_neg_out, 1'b0);
    rst = 1'b0;
    repeat (3) send_bit(1'b1);
  endtask

  task automatic t_zero_run;
    send_bit(1'b1);
    for (int i = 0; i < 32; i++) send_bit(1'b0);
    idle_low(4);
    chk("R1 32 zeros keep los_n high", los_n, 1'b1);
    send_bit(1'b0);
    idle_low(4);
    chk("R1 33rd zero lowers los_n", los_n, 1'b0);
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    idle_low(4);
    chk("R2 long run stays in alarm", los_n, 1'b0);
    chk("R5 no shutdown keeps loc_n high", loc_n, 1'b1);
    send_bit(1'b1);
    idle_low(4);
    chk("R2 first mark clears los_n", los_n, 1'b1);
    send_bit(1'b1);
  endtask

  task automatic t_analog;
    ana_los = 1'b1;
    send_bit(1'b1);
    chk("R3 analog alone lowers los_n", los_n, 1'b0);
    loop_local = 1'b1;
    send_bit(1'b1);
    chk("R4 loopback ignores analog", los_n, 1'b1);
    loop_local = 1'b0;
    ana_los = 1'b0;
    send_bit(1'b1);
    chk("R3 analog clear restores los_n", los_n, 1'b1);
  endtask

  task automatic t_shutdown;
    sd_en = 1'b1; ana_los = 1'b1;
    dual_rail = 1'b0; inv_mode = 1'b0;
    send_bit(1'b1);
    chk("R5 loc_n low", loc_n, 1'b0);
    chk("R8 clk_out", rx_clk_out, 1'b1);
    chk("R8 pos_out", rx_pos_out, 1'b0);
    chk("R8 neg_out", rx_neg_out, 1'b0);
    dual_rail = 1'b1;
    send_bit(1'b1);
    chk("R9 clk_out", rx_clk_out, 1'b1);
    chk("R9 pos_out", rx_pos_out, 1'b0);
    chk("R9 neg_out", rx_neg_out, 1'b0);
    inv_mode = 1'b1;
    send_bit(1'b1);
    chk("R10 clk_out", rx_clk_out, 1'b0);
    chk("R10 pos_out", rx_pos_out, 1'b1);
    chk("R10 neg_out", rx_neg_out, 1'b1);
    sd_en = 1'b0; ana_los = 1'b0; dual_rail = 1'b0; inv_mode = 1'b0;
    send_bit(1'b1);
    chk("R5 loc_n released", loc_n, 1'b1);
  endtask

  // negative rail only is a mark; check both clock phases after 5 cycles
  task automatic pass_case(input string req, input logic dr, input logic inv,
                           input logic c_lo, input logic c_hi,
                           input logic p_exp, input logic n_exp);
    dual_rail = dr; inv_mode = inv;
    rx_pos_in = 1'b0; rx_neg_in = 1'b1;
    rx_clk_in = 1'b0;
    wait_n(5);
    chk({req, " clk low phase"}, rx_clk_out, c_lo);
    chk({req, " pos"}, rx_pos_out, p_exp);
    chk({req, " neg"}, rx_neg_out, n_exp);
    rx_clk_in = 1'b1;
    wait_n(5);
    chk({req, " clk high phase"}, rx_clk_out, c_hi);
  endtask

  task automatic t_pass;
    pass_case("R11 single", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    pass_case("R11 dual true", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    pass_case("R11 dual inv", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    dual_rail = 1'b0; inv_mode = 1'b0;
    send_bit(1'b1);
  endtask

  task automatic t_alarm_test;
    sd_en = 1'b1;
    alm_test_n = 1'b0;
    pass_case("R12 data unaffected", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R12 los_n", los_n, 1'b0);
    chk("R12 loc_n", loc_n, 1'b0);
    alm_test_n = 1'b1;
    sd_en = 1'b0;
    send_bit(1'b1);
    chk("R12 release los_n", los_n, 1'b1);
    chk("R12 release loc_n", loc_n, 1'b1);
  endtask

  task automatic t_clock_loss;
    send_bit(1'b1);
    send_bit(1'b1);
    rx_clk_in = 1'b0;
    wait_n(6);
    chk("R6 short gap not flagged", loc_n, 1'b1);
    wait_n(20);
    chk("R6 stopped clock lowers loc_n", loc_n, 1'b0);
    rx_clk_in = 1'b1;
    wait_n(8);
    chk("R7 restored within 8 cycles", loc_n, 1'b1);
    send_bit(1'b1);
    chk("R7 stays restored", loc_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_zero_run();
    t_analog();
    t_shutdown();
    t_pass();
    t_alarm_test();
    t_clock_loss();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule